// File: doc/BRIEF.md
# High-Speed OUT/PING Token Selector

This block holds the flow-control state of one host-side queue head for a high-speed bulk or control OUT endpoint. It decides whether the next transaction opens with an OUT token or a PING token. After each transaction the host engine strobes in the handshake result. The block then updates its two-valued state (Do-OUT or Do-PING) and tells the engine three things: whether to move the transfer forward, whether to halt the queue, and which token to issue next.

The state is maintained only for queue heads that may use the ping protocol. Such a queue head is not an interrupt queue head, is not a split-transaction stream, runs at high speed and carries the OUT PID. For any other queue head the state is frozen and the token is always OUT. Software seeds the state when it initialises the queue head. Reloading the overlay with a new transfer descriptor keeps the state the block already holds.

Top module: `usbp_ping_ctrl`

## Requirements
- R1: The queue head qualifies only when `qh_intr`=0, `qh_split`=0, `qh_speed` equals SPD_HS (default 2'b10) and `qh_pid` equals PID_OUT (default 2'b00). When it does not qualify, `ping_state` does not change, and an ACK or NYET pulses `xfer_adv`.
- R2: With `ping_state`=0 (Do-OUT) and a qualifying queue head, ACK keeps Do-OUT and pulses `xfer_adv`. NAK or a missed handshake moves the state to Do-PING (1) with no advance.
- R3: With Do-OUT and a qualifying queue head, NYET pulses `xfer_adv` and also moves the state to Do-PING.
- R4: With Do-PING and a qualifying queue head, ACK returns the state to Do-OUT without advancing. NAK or a missed handshake leave it at Do-PING.
- R5: STALL, in either state and whether or not the queue head qualifies, leaves `ping_state` unchanged. It sets `halt` and pulses `active_clr` for one cycle. While `halt` is 1, handshake results change nothing and produce no pulses.
- R6: `token_ping` is registered. In the cycle after any clock it equals (qualifies AND new `ping_state`); 1 means PING and 0 means OUT.
- R7: `hs_code` is one-hot: bit0 ACK, bit1 NAK, bit2 NYET, bit3 STALL, bit4 missed handshake. A strobe with any other value is ignored, and `code_err` pulses for one cycle.
- R8: `qh_init` loads `ping_state` from `sw_ping_init` and clears `halt`. It overrides `qtd_load` and any handshake in the same cycle.
- R9: `qtd_load` clears `halt`, keeps `ping_state` whatever `sw_ping_init` holds, and overrides a handshake in the same cycle.
- R10: Synchronous active-high `rst` loads `ping_state` from `sw_ping_init` and clears `halt`, `xfer_adv`, `active_clr`, `code_err` and `token_ping`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qh_intr | input | 1 | Queue head is an interrupt queue head |
| qh_split | input | 1 | Queue head is a split-transaction stream |
| qh_speed | input | SPD_W | Endpoint speed code |
| qh_pid | input | PID_W | PID code of the queue head |
| sw_ping_init | input | 1 | Software initial ping state |
| qh_init | input | 1 | Software initialises the queue head |
| qtd_load | input | 1 | New transfer descriptor written to the overlay |
| hs_vld | input | 1 | Handshake result strobe |
| hs_code | input | 5 | One-hot handshake result |
| ping_state | output | 1 | 0 = Do-OUT, 1 = Do-PING |
| token_ping | output | 1 | Next token: 1 = PING, 0 = OUT |
| xfer_adv | output | 1 | Advance-transfer pulse |
| halt | output | 1 | Queue halted |
| active_clr | output | 1 | Clear-active pulse |
| code_err | output | 1 | Malformed handshake code pulse |

## Verification
The hardest situation to reach is a collision: a handshake strobe arrives while the queue is halted, or in the same cycle as a queue-head initialisation or a descriptor reload. The outcome then depends on priority rather than on the transition table. The stimulus first halts the queue with STALL and sends NAKs into the halted queue. It then restarts the queue with a reload while driving the opposite seed value, and finally fires `qh_init` together with a NAK. Only the loaded value may survive. The reference model predicts every output on every clock, so a wrong priority shows up at once as a miscompare on `ping_state` or `halt`.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

   localparam int HS_W      = 5;
   localparam int HS_ACK    = 0;
   localparam int HS_NAK    = 1;
   localparam int HS_NYET   = 2;
   localparam int HS_STALL  = 3;
   localparam int HS_XERR   = 4;

   typedef enum logic {
      PS_DO_OUT  = 1'b0,
      PS_DO_PING = 1'b1
   } ping_st_e;

endpackage

// File: rtl/usbp_qual.sv
module usbp_qual #(
   parameter int SPD_W   = 2,
   parameter int SPD_HS  = 2,
   parameter int PID_W   = 2,
   parameter int PID_OUT = 0
) (
   input  logic             qh_intr,
   input  logic             qh_split,
   input  logic [SPD_W-1:0] qh_speed,
   input  logic [PID_W-1:0] qh_pid,
   output logic             qual
);

   localparam logic [SPD_W-1:0] HS_CODE  = SPD_W'(SPD_HS);
   localparam logic [PID_W-1:0] OUT_CODE = PID_W'(PID_OUT);

   logic speed_ok;
   logic pid_ok;

   assign speed_ok = (qh_speed == HS_CODE);
   assign pid_ok   = (qh_pid == OUT_CODE);
   assign qual     = speed_ok & pid_ok & ~qh_intr & ~qh_split;

endmodule

// File: rtl/usbp_hs_decode.sv
module usbp_hs_decode #(
   parameter int HS_W   = 5,
   parameter bit STRICT = 1'b1
) (
   input  logic            hs_vld,
   input  logic [HS_W-1:0] hs_code,
   output logic [HS_W-1:0] ev,
   output logic            ev_vld,
   output logic            bad
);

   logic onehot;

   assign onehot = $onehot(hs_code);
   assign bad    = hs_vld & ~onehot;

   generate
      if (STRICT) begin : g_strict
         assign ev_vld = hs_vld & onehot;
         assign ev     = onehot ? hs_code : '0;
      end else begin : g_lowest
         logic [HS_W-1:0] pick;
         always_comb begin
            pick = '0;
            for (int i = HS_W - 1; i >= 0; i--) begin
               if (hs_code[i]) pick = HS_W'(1) << i;
            end
         end
         assign ev_vld = hs_vld & (|hs_code);
         assign ev     = pick;
      end
   endgenerate

endmodule

// File: rtl/usbp_ping_fsm.sv
module usbp_ping_fsm
   import usbp_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            sw_ping_init,
   input  logic            qh_init,
   input  logic            qtd_load,
   input  logic            qual,
   input  logic            ev_vld,
   input  logic [HS_W-1:0] ev,
   output logic            ping_q,
   output logic            ping_d,
   output logic            halt_q,
   output logic            adv_q,
   output logic            aclr_q
);

   ping_st_e st_q, st_d;
   logic     halt_d, adv_d, aclr_d;
   logic     take;

   assign take = ev_vld & ~halt_q & ~qh_init & ~qtd_load;

   always_comb begin
      st_d   = st_q;
      halt_d = halt_q;
      adv_d  = 1'b0;
      aclr_d = 1'b0;
      if (qh_init) begin
         st_d   = ping_st_e'(sw_ping_init);
         halt_d = 1'b0;
      end else if (qtd_load) begin
         halt_d = 1'b0;
      end else if (take) begin
         if (ev[HS_STALL]) begin
            halt_d = 1'b1;
            aclr_d = 1'b1;
         end else if (!qual) begin
            adv_d = ev[HS_ACK] | ev[HS_NYET];
         end else if (st_q == PS_DO_OUT) begin
            adv_d = ev[HS_ACK] | ev[HS_NYET];
            if (ev[HS_NAK] | ev[HS_NYET] | ev[HS_XERR]) st_d = PS_DO_PING;
         end else begin
            if (ev[HS_ACK]) st_d = PS_DO_OUT;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ping_st_e'(sw_ping_init);
         halt_q <= 1'b0;
         adv_q  <= 1'b0;
         aclr_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         halt_q <= halt_d;
         adv_q  <= adv_d;
         aclr_q <= aclr_d;
      end
   end

   assign ping_q = (st_q == PS_DO_PING);
   assign ping_d = (st_d == PS_DO_PING);

   p_stall_halts_r5: assert property (@(posedge clk) disable iff (rst)
      (ev_vld && ev[HS_STALL] && !halt_q && !qh_init && !qtd_load) |=> (halt_q && aclr_q && $stable(st_q)));

   p_halt_frozen_r5: assert property (@(posedge clk) disable iff (rst)
      (halt_q && !qh_init && !qtd_load) |=> ($stable(st_q) && !adv_q && !aclr_q));

   p_unqual_keep_r1: assert property (@(posedge clk) disable iff (rst)
      (!qual && !qh_init) |=> $stable(st_q));

   p_nyet_adv_r3: assert property (@(posedge clk) disable iff (rst)
      (ev_vld && ev[HS_NYET] && qual && st_q == PS_DO_OUT && !halt_q && !qh_init && !qtd_load)
      |=> (adv_q && st_q == PS_DO_PING));

   p_init_load_r8: assert property (@(posedge clk) disable iff (rst)
      qh_init |=> (st_q == ping_st_e'($past(sw_ping_init)) && !halt_q));

   p_reload_keeps_r9: assert property (@(posedge clk) disable iff (rst)
      (qtd_load && !qh_init) |=> ($stable(st_q) && !halt_q));

   p_pulse_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(adv_q && aclr_q));

endmodule

// File: rtl/usbp_ping_ctrl.sv
module usbp_ping_ctrl #(
   parameter int SPD_W      = 2,
   parameter int SPD_HS     = 2,
   parameter int PID_W      = 2,
   parameter int PID_OUT    = 0,
   parameter bit STRICT_HS  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             qh_intr,
   input  logic             qh_split,
   input  logic [SPD_W-1:0] qh_speed,
   input  logic [PID_W-1:0] qh_pid,
   input  logic             sw_ping_init,
   input  logic             qh_init,
   input  logic             qtd_load,
   input  logic             hs_vld,
   input  logic [4:0]       hs_code,
   output logic             ping_state,
   output logic             token_ping,
   output logic             xfer_adv,
   output logic             halt,
   output logic             active_clr,
   output logic             code_err
);
   import usbp_pkg::*;

   initial begin
      a_spd_w: assert (SPD_W >= 1 && SPD_HS < (1 << SPD_W));
      a_pid_w: assert (PID_W >= 1 && PID_OUT < (1 << PID_W));
      a_hs_w:  assert (HS_W == 5);
   end

   logic            qual;
   logic [HS_W-1:0] ev;
   logic            ev_vld;
   logic            bad;
   logic            ping_d;
   logic            token_q;
   logic            err_q;

   usbp_qual #(
      .SPD_W   (SPD_W),
      .SPD_HS  (SPD_HS),
      .PID_W   (PID_W),
      .PID_OUT (PID_OUT)
   ) u_qual (
      .qh_intr  (qh_intr),
      .qh_split (qh_split),
      .qh_speed (qh_speed),
      .qh_pid   (qh_pid),
      .qual     (qual)
   );

   usbp_hs_decode #(
      .HS_W   (HS_W),
      .STRICT (STRICT_HS)
   ) u_dec (
      .hs_vld  (hs_vld),
      .hs_code (hs_code),
      .ev      (ev),
      .ev_vld  (ev_vld),
      .bad     (bad)
   );

   usbp_ping_fsm u_fsm (
      .clk          (clk),
      .rst          (rst),
      .sw_ping_init (sw_ping_init),
      .qh_init      (qh_init),
      .qtd_load     (qtd_load),
      .qual         (qual),
      .ev_vld       (ev_vld),
      .ev           (ev),
      .ping_q       (ping_state),
      .ping_d       (ping_d),
      .halt_q       (halt),
      .adv_q        (xfer_adv),
      .aclr_q       (active_clr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         token_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         token_q <= qual & ping_d;
         err_q   <= bad;
      end
   end

   assign token_ping = token_q;
   assign code_err   = err_q;

   p_token_state_r6: assert property (@(posedge clk) disable iff (rst)
      token_ping |-> ping_state);

   p_unqual_out_r6: assert property (@(posedge clk) disable iff (rst)
      !qual |=> !token_ping);

   p_bad_code_r7: assert property (@(posedge clk) disable iff (rst)
      (hs_vld && !$onehot(hs_code) && !qh_init && !qtd_load && STRICT_HS)
      |=> (code_err && $stable(ping_state) && !xfer_adv && !active_clr));

endmodule

// File: tb/usbp_ping_ctrl_test.sv
module usbp_ping_ctrl_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       qh_intr, qh_split;
   logic [1:0] qh_speed, qh_pid;
   logic       sw_ping_init, qh_init, qtd_load, hs_vld;
   logic [4:0] hs_code;
   logic       ping_state, token_ping, xfer_adv, halt, active_clr, code_err;

   int  vectors = 0;
   int  misses  = 0;
   bit  done    = 0;

   bit  m_ping, m_halt, m_adv, m_aclr, m_err, m_tok;

   localparam logic [4:0] ACK = 5'b00001, NAK = 5'b00010, NYET = 5'b00100,
                          STL = 5'b01000, XER = 5'b10000;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbp_ping_ctrl uut (
      .clk(clk), .rst(rst), .qh_intr(qh_intr), .qh_split(qh_split),
      .qh_speed(qh_speed), .qh_pid(qh_pid), .sw_ping_init(sw_ping_init),
      .qh_init(qh_init), .qtd_load(qtd_load), .hs_vld(hs_vld), .hs_code(hs_code),
      .ping_state(ping_state), .token_ping(token_ping), .xfer_adv(xfer_adv),
      .halt(halt), .active_clr(active_clr), .code_err(code_err)
   );

   task automatic cmp(input string tag, input string nm, input bit act, input bit exp);
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, nm, act, exp);
      end
   endtask

   function automatic bit qualifies();
      return !qh_intr && !qh_split && qh_speed == 2'b10 && qh_pid == 2'b00;
   endfunction

   task automatic model();
      bit q, one, take;
      q    = qualifies();
      one  = (hs_code == ACK) || (hs_code == NAK) || (hs_code == NYET) ||
             (hs_code == STL) || (hs_code == XER);
      m_err  = hs_vld && !one;
      m_adv  = 0;
      m_aclr = 0;
      if (rst) begin
         m_ping = sw_ping_init; m_halt = 0; m_err = 0; m_tok = 0;
         return;
      end
      take = hs_vld && one && !m_halt && !qh_init && !qtd_load;
      if (qh_init) begin
         m_ping = sw_ping_init; m_halt = 0;
      end else if (qtd_load) begin
         m_halt = 0;
      end else if (take) begin
         if (hs_code == STL) begin
            m_halt = 1; m_aclr = 1;
         end else if (!q) begin
            m_adv = (hs_code == ACK) || (hs_code == NYET);
         end else if (!m_ping) begin
            m_adv = (hs_code == ACK) || (hs_code == NYET);
            if (hs_code != ACK) m_ping = 1;
         end else if (hs_code == ACK) begin
            m_ping = 0;
         end
      end
      m_tok = q && m_ping;
   endtask

   task automatic step(input string tag, input bit v, input logic [4:0] oc,
                       input bit ini = 0, input bit ld = 0);
      @(negedge clk);
      hs_vld = v; hs_code = oc; qh_init = ini; qtd_load = ld;
      model();
      @(posedge clk);
      #1;
      vectors++;
      cmp(tag, "ping_state", ping_state, m_ping);
      cmp(tag, "halt",       halt,       m_halt);
      cmp(tag, "xfer_adv",   xfer_adv,   m_adv);
      cmp(tag, "active_clr", active_clr, m_aclr);
      cmp(tag, "code_err",   code_err,   m_err);
      cmp(tag, "token_ping", token_ping, m_tok);
   endtask

   task automatic attrs(input bit intr, input bit spl, input logic [1:0] spd, input logic [1:0] pid);
      qh_intr = intr; qh_split = spl; qh_speed = spd; qh_pid = pid;
   endtask

   initial begin
      rst = 1; sw_ping_init = 0; qh_init = 0; qtd_load = 0; hs_vld = 0; hs_code = 0;
      attrs(0, 0, 2'b10, 2'b00);
      step("R10 reset seed 0", 0, 0);
      step("R10 reset seed 0", 0, 0);
      rst = 0;
      step("R10 idle", 0, 0);
      // R2 / R3 / R4 transition table, qualifying queue head
      step("R2 OUT ack",    1, ACK);
      step("R2 OUT nak",    1, NAK);
      step("R6 token ping", 0, 0);
      step("R4 PING nak",   1, NAK);
      step("R4 PING xerr",  1, XER);
      step("R4 PING ack",   1, ACK);
      step("R3 OUT nyet",   1, NYET);
      step("R4 PING ack",   1, ACK);
      step("R2 OUT xerr",   1, XER);
      step("R4 PING ack",   1, ACK);
      step("R2 OUT ack",    1, ACK);
      step("R3 OUT nyet",   1, NYET);
      // R9 reload keeps state despite opposite seed
      sw_ping_init = 0;
      step("R9 reload keeps", 0, 0, 0, 1);
      step("R9 reload beats nak", 1, NAK, 0, 1);
      // R1 unqualified queue heads freeze state
      attrs(1, 0, 2'b10, 2'b00);
      step("R1 intr ack",  1, ACK);
      step("R1 intr nyet", 1, NYET);
      attrs(0, 0, 2'b01, 2'b00);
      step("R1 full speed ack", 1, ACK);
      attrs(0, 0, 2'b10, 2'b01);
      step("R1 pid in ack", 1, ACK);
      attrs(0, 1, 2'b10, 2'b00);
      step("R1 split ack", 1, ACK);
      step("R1 split nak", 1, NAK);
      attrs(0, 0, 2'b10, 2'b00);
      step("R6 requalified", 0, 0);
      // R7 malformed codes
      step("R7 zero code",  1, 5'b00000);
      step("R7 two bits",   1, 5'b00011);
      step("R7 all bits",   1, 5'b11111);
      step("R7 no strobe",  0, 5'b00011);
      // R5 stall and halted behaviour
      step("R5 stall in PING", 1, STL);
      step("R5 halted ack",    1, ACK);
      step("R5 halted nyet",   1, NYET);
      step("R5 halted stall",  1, STL);
      step("R9 restart", 0, 0, 0, 1);
      step("R4 PING ack", 1, ACK);
      step("R5 stall in OUT", 1, STL);
      step("R5 halted nak", 1, NAK);
      attrs(1, 0, 2'b10, 2'b00);
      step("R9 restart unqual", 0, 0, 0, 1);
      step("R5 stall unqual", 1, STL);
      attrs(0, 0, 2'b10, 2'b00);
      // R8 init overrides everything
      sw_ping_init = 1;
      step("R8 init with nak", 1, NAK, 1, 1);
      step("R6 token after init", 0, 0);
      sw_ping_init = 0;
      step("R8 init to OUT", 1, XER, 1, 0);
      step("R2 OUT nak", 1, NAK);
      // R10 reset with seed 1 mid-run
      sw_ping_init = 1; rst = 1;
      step("R10 reset seed 1", 1, ACK);
      rst = 0;
      step("R4 PING ack after reset", 1, ACK);
      step("R2 idle", 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule